// File: doc/BRIEF.md
# Two-Address ALU with Cascade Forwarding

This block is the execute stage for the arithmetic and bitwise instructions of a two-address 32-bit core. Each issued instruction brings the current value of its destination register, a source operand (a register value or a short immediate, possibly widened from an extension word), an operation class and three control bits. It returns the result and the negative, zero, carry and overflow flags one clock later, together with a write-enable for the register file.

One adder produces eight move and arithmetic operations. The control bits choose whether the old destination is accumulated, whether the source is inverted, and the carry-in value. Two of those combinations take their carry-in from the stored carry flag, which gives add-with-carry and subtract-with-borrow. A second datapath produces eight bitwise operations from the same three bits.

When the cascade bit is set, the destination register is only read and nothing is written back. The result is held in a forward register and replaces the destination operand of the next instruction. If that next instruction is neither arithmetic nor bitwise, the held value is dropped, but the flags set by the cascade remain. A shift-unit neighbour can read the held value from the forward ports.

Top module: `casc_alu`

## Requirements
- R1: During and after a synchronous reset, `out_valid`, `wr_en`, `err_double`, `fwd_valid`, `result` and all four flags read 0 until the first issue.
- R2: In math class (`op_class`=0) with `ctl[2]`=0, the result is S+`ctl[0]`, where S is the source, bitwise inverted when `ctl[1]`=1. This gives move, increment, invert and negate.
- R3: In math class with `ctl`=3'b100 or 3'b111, the result is D+S+`ctl[0]`, where D is the destination operand. This gives add and subtract.
- R4: In math class with `ctl`=3'b101 or 3'b110, the carry-in is the `carry_flag` input, not `ctl[0]`.
- R5: In logic class (`op_class`=1), the result is `ctl[1]` XOR (`ctl[2]` ? (S AND (D XOR {32{`ctl[0]`}})) : (`ctl[0]` ? S XOR D : S OR D)), with S never inverted.
- R6: After a math instruction, `flag_n` is result bit 31, `flag_z` is set when the result is zero, `flag_c` is the adder carry-out from bit 31, and `flag_v` is set on signed overflow of the addition.
- R7: After a logic instruction, N and Z follow the result and C and V read 0.
- R8: With `src_imm_sel`=1, an `imm4` of 0..13 is zero-extended, 14 takes `ext_word[15:0]` zero-extended, and 15 takes all 32 bits of `ext_word`.
- R9: A math or logic instruction with `cascade`=1 gives `wr_en`=0 and `fwd_valid`=1. The next math or logic instruction uses the forwarded value in place of `dst_val`.
- R10: An instruction of shift (2) or other (3) class gives `wr_en`=0, clears `fwd_valid`, leaves all four flags unchanged, and causes the next instruction to use `dst_val`.
- R11: A cascade issued while `fwd_valid`=1 raises `err_double` with its result and replaces the forwarded value.
- R12: Results, flags, `wr_en` and `out_valid` appear in the cycle after the issue cycle. `wr_en` is 1 only for a non-cascade math or logic instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| op_class | input | 2 | 0 math, 1 logic, 2 shift, 3 other |
| ctl | input | 3 | Accumulate, invert, carry/modifier bits |
| cascade | input | 1 | Forward result instead of writing it |
| dst_val | input | 32 | Destination register value |
| src_reg | input | 32 | Source register value |
| src_imm_sel | input | 1 | Source is the immediate |
| imm4 | input | 4 | Short immediate field |
| ext_word | input | 32 | Extension word(s) after the instruction |
| carry_flag | input | 1 | Stored carry flag |
| out_valid | output | 1 | Result of last issue present |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| wr_en | output | 1 | Write result to destination register |
| err_double | output | 1 | Back-to-back cascade detected |
| fwd_valid | output | 1 | Forwarded value pending |
| fwd_data | output | 32 | Forwarded value |

## Verification
The bench targets the two carry-in combinations that use the stored flag. A design that used the instruction bit there would return results one off whenever `carry_flag` and `ctl[0]` differ. It also checks the signed-overflow and carry-out edges, such as 0x7FFFFFFF+1 and a subtraction with equal operands: mixing up carry and overflow would show the wrong C or V on those. It follows a cascade with each kind of successor. A forward that outlived a shift-class or other-class instruction would corrupt a later add, and a forward that was never applied would leave the add using the register value. Both extension immediate widths are checked, where sign-extending or truncating the wrong way gives a visibly different value.

// File: rtl/casc_alu_pkg.sv
package casc_alu_pkg;

    typedef enum logic [1:0] {
        CLS_MATH  = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_OTHER = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // add-with-carry and subtract-with-borrow take the stored carry
    function automatic logic carry_from_flag(input logic [2:0] bits);
        return (bits == 3'b101) || (bits == 3'b110);
    endfunction

    function automatic logic is_alu_class(input op_cls_e cls);
        return (cls == CLS_MATH) || (cls == CLS_LOGIC);
    endfunction

endpackage

// File: rtl/casc_src_select.sv
module casc_src_select #(
    parameter int W    = 32,
    parameter int IMMW = 4,
    parameter int SHORTW = 16
) (
    input  logic            use_imm,
    input  logic [IMMW-1:0] imm,
    input  logic [W-1:0]    reg_val,
    input  logic [W-1:0]    ext,
    output logic [W-1:0]    operand
);
    localparam logic [IMMW-1:0] CODE_LONG  = IMMW'((1 << IMMW) - 1);
    localparam logic [IMMW-1:0] CODE_SHORT = IMMW'((1 << IMMW) - 2);

    always_comb begin
        if (!use_imm)
            operand = reg_val;
        else if (imm == CODE_LONG)
            operand = ext;
        else if (imm == CODE_SHORT)
            operand = {{(W-SHORTW){1'b0}}, ext[SHORTW-1:0]};
        else
            operand = {{(W-IMMW){1'b0}}, imm};
    end
endmodule

// File: rtl/casc_math_unit.sv
module casc_math_unit
    import casc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   bits,
    input  logic         stored_c,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output logic [W-1:0] res,
    output flags_t       fl
);
    logic [W-1:0] opa, opb;
    logic         cin;
    logic [W:0]   sum;

    always_comb begin
        opa = bits[2] ? dst : '0;
        opb = bits[1] ? ~src : src;
        cin = carry_from_flag(bits) ? stored_c : bits[0];
        sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
        res = sum[W-1:0];
        fl.n = sum[W-1];
        fl.z = (sum[W-1:0] == '0);
        fl.c = sum[W];
        fl.v = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
    end
endmodule

// File: rtl/casc_logic_unit.sv
module casc_logic_unit
    import casc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   bits,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output logic [W-1:0] res,
    output flags_t       fl
);
    logic [W-1:0] mod_mask, core;

    always_comb begin
        mod_mask = {W{bits[0]}};
        if (bits[2])
            core = src & (dst ^ mod_mask);
        else if (bits[0])
            core = src ^ dst;
        else
            core = src | dst;
        res  = bits[1] ? ~core : core;
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.c = 1'b0;
        fl.v = 1'b0;
    end
endmodule

// File: rtl/casc_alu.sv
module casc_alu
    import casc_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  logic [1:0]      op_class,
    input  logic [2:0]      ctl,
    input  logic            cascade,
    input  logic [W-1:0]    dst_val,
    input  logic [W-1:0]    src_reg,
    input  logic            src_imm_sel,
    input  logic [IMMW-1:0] imm4,
    input  logic [W-1:0]    ext_word,
    input  logic            carry_flag,
    output logic            out_valid,
    output logic [W-1:0]    result,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flag_v,
    output logic            wr_en,
    output logic            err_double,
    output logic            fwd_valid,
    output logic [W-1:0]    fwd_data
);
    op_cls_e      cls;
    logic         alu_op;
    logic [W-1:0] src_op, dst_op;
    logic [W-1:0] math_res, logic_res, sel_res;
    flags_t       math_fl, logic_fl, sel_fl, flags_q;

    assign cls    = op_cls_e'(op_class);
    assign alu_op = is_alu_class(cls);
    assign dst_op = fwd_valid ? fwd_data : dst_val;

    casc_src_select #(.W(W), .IMMW(IMMW)) u_src (
        .use_imm (src_imm_sel),
        .imm     (imm4),
        .reg_val (src_reg),
        .ext     (ext_word),
        .operand (src_op)
    );

    casc_math_unit #(.W(W)) u_math (
        .bits     (ctl),
        .stored_c (carry_flag),
        .dst      (dst_op),
        .src      (src_op),
        .res      (math_res),
        .fl       (math_fl)
    );

    casc_logic_unit #(.W(W)) u_logic (
        .bits (ctl),
        .dst  (dst_op),
        .src  (src_op),
        .res  (logic_res),
        .fl   (logic_fl)
    );

    assign sel_res = (cls == CLS_LOGIC) ? logic_res : math_res;
    assign sel_fl  = (cls == CLS_LOGIC) ? logic_fl  : math_fl;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            flags_q    <= '0;
            wr_en      <= 1'b0;
            err_double <= 1'b0;
            fwd_valid  <= 1'b0;
            fwd_data   <= '0;
        end else begin
            out_valid  <= issue_valid;
            err_double <= issue_valid && alu_op && cascade && fwd_valid;
            if (issue_valid) begin
                fwd_valid <= alu_op && cascade;
                if (alu_op) begin
                    result  <= sel_res;
                    flags_q <= sel_fl;
                    wr_en   <= !cascade;
                    if (cascade)
                        fwd_data <= sel_res;
                end else begin
                    result <= '0;
                    wr_en  <= 1'b0;
                end
            end else begin
                wr_en <= 1'b0;
            end
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // R12
    wr_en_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    // R9
    cascade_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && cascade && !op_class[1]) |=> (!wr_en && fwd_valid));

    // R7
    logic_clears_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op_class == 2'd1) |=> (!flag_c && !flag_v));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op_class[1]) |=> ($stable({flag_n, flag_z, flag_c, flag_v}) && !fwd_valid));

    // R11
    double_cascade_chk: assert property (@(posedge clk) disable iff (rst)
        err_double |-> ($past(fwd_valid) && fwd_valid));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !op_class[1]) |=> (flag_z == (result == '0)));

endmodule

// File: tb/casc_alu_tb.sv
`timescale 1ns/1ps
module casc_alu_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [1:0]  op_class;
    logic [2:0]  ctl;
    logic        cascade;
    logic [31:0] dst_val, src_reg, ext_word;
    logic        src_imm_sel;
    logic [3:0]  imm4;
    logic        carry_flag;
    logic        out_valid, flag_n, flag_z, flag_c, flag_v, wr_en, err_double, fwd_valid;
    logic [31:0] result, fwd_data;

    always #4 clk = ~clk;

    casc_alu u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_class(op_class),
        .ctl(ctl), .cascade(cascade), .dst_val(dst_val), .src_reg(src_reg),
        .src_imm_sel(src_imm_sel), .imm4(imm4), .ext_word(ext_word),
        .carry_flag(carry_flag), .out_valid(out_valid), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .wr_en(wr_en), .err_double(err_double), .fwd_valid(fwd_valid),
        .fwd_data(fwd_data)
    );

    typedef struct {
        logic [31:0] res;
        logic [3:0]  fl;
        logic        we;
        logic        err;
        logic        fv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails  = 0;
    logic        m_fv = 1'b0;
    logic [31:0] m_fd = '0;
    logic [3:0]  m_fl = '0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: model from requirements, push expectation, drive inputs
    task automatic issue(input logic [1:0] cls, input logic [2:0] c, input logic k,
                         input logic [31:0] d, input logic [31:0] s, input logic isel,
                         input logic [3:0] im, input logic [31:0] ex, input logic cf,
                         input string tag);
        exp_t        e;
        logic [31:0] so, dop, opa, opb, r;
        logic [32:0] s33;
        logic        cin;
        @(negedge clk);
        if (!isel)        so = s;
        else if (im == 15) so = ex;
        else if (im == 14) so = {16'h0, ex[15:0]};
        else              so = {28'h0, im};
        dop = (m_fv && !cls[1]) ? m_fd : d;
        r = '0;
        if (cls == 2'd0) begin
            opa = c[2] ? dop : 32'h0;
            opb = c[1] ? ~so : so;
            cin = (c == 3'b101 || c == 3'b110) ? cf : c[0];
            s33 = {1'b0, opa} + {1'b0, opb} + {32'h0, cin};
            r = s33[31:0];
            m_fl = {r[31], r == 0, s33[32], (opa[31] == opb[31]) && (r[31] != opa[31])};
        end else if (cls == 2'd1) begin
            if (c[2])      r = so & (dop ^ {32{c[0]}});
            else if (c[0]) r = so ^ dop;
            else           r = so | dop;
            if (c[1]) r = ~r;
            m_fl = {r[31], r == 0, 1'b0, 1'b0};
        end
        e.res = r;
        e.fl  = m_fl;
        e.we  = !cls[1] && !k;
        e.err = !cls[1] && k && m_fv;
        e.fv  = !cls[1] && k;
        e.tag = tag;
        sb.push_back(e);
        m_fv = e.fv;
        if (e.fv) m_fd = r;
        issue_valid = 1'b1; op_class = cls; ctl = c; cascade = k;
        dst_val = d; src_reg = s; src_imm_sel = isel; imm4 = im;
        ext_word = ex; carry_flag = cf;
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    // monitor: one cycle after issue, compare with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R12 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result/flags"}, {result, flag_n, flag_z, flag_c, flag_v},
                      {e.res, e.fl});
                check({e.tag, " wr_en/err/fwd"}, {wr_en, err_double, fwd_valid},
                      {e.we, e.err, e.fv});
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; op_class = 2'd0; ctl = 3'd0; cascade = 1'b0;
        dst_val = '0; src_reg = '0; src_imm_sel = 1'b0; imm4 = '0; ext_word = '0;
        carry_flag = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {out_valid, wr_en, err_double, fwd_valid, flag_n, flag_z,
              flag_c, flag_v, result}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {out_valid, wr_en, fwd_valid, result}, 64'd0);

        // R2 move family
        issue(0, 3'b000, 0, 32'h1234, 32'h5, 0, 0, 0, 1, "R2 MOV");
        issue(0, 3'b001, 0, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2/R6/R12 INC carry-out");
        issue(0, 3'b010, 0, 32'h0, 32'h0, 0, 0, 0, 0, "R2 NOT");
        issue(0, 3'b011, 0, 32'h0, 32'h1, 0, 0, 0, 0, "R2 NEG");
        // R3 add / subtract, R6 overflow and carry
        issue(0, 3'b100, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1, "R3/R6 ADD overflow");
        issue(0, 3'b111, 0, 32'h5, 32'h5, 0, 0, 0, 0, "R3/R6 SUB equal");
        issue(0, 3'b111, 0, 32'h3, 32'h5, 0, 0, 0, 1, "R3/R6 SUB borrow");
        // R4 stored-carry forms
        issue(0, 3'b101, 0, 32'h1, 32'h1, 0, 0, 0, 1, "R4 ADC cf=1");
        issue(0, 3'b101, 0, 32'h1, 32'h1, 0, 0, 0, 0, "R4 ADC cf=0");
        issue(0, 3'b110, 0, 32'h5, 32'h3, 0, 0, 0, 0, "R4 SBB cf=0");
        issue(0, 3'b110, 0, 32'h5, 32'h3, 0, 0, 0, 1, "R4 SBB cf=1");
        // R5 / R7 all eight bitwise forms
        for (int i = 0; i < 8; i++)
            issue(1, 3'(i), 0, 32'hF0F0_00FF, 32'hFF00_0F0F, 0, 0, 0, 1, "R5/R7 logic");
        issue(1, 3'b100, 0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, 0, 0, 1, "R5/R7 AND zero");
        // R8 immediates
        issue(0, 3'b000, 0, 0, 32'hDEAD_BEEF, 1, 4'd13, 32'hFFFF_FFFF, 0, "R8 imm13");
        issue(0, 3'b000, 0, 0, 32'hDEAD_BEEF, 1, 4'd14, 32'hABCD_9234, 0, "R8 ext16");
        issue(0, 3'b000, 0, 0, 32'hDEAD_BEEF, 1, 4'd15, 32'hABCD_9234, 0, "R8 ext32");
        idle();
        idle();
        // R9 cascade into add
        issue(0, 3'b111, 1, 32'd10, 32'd3, 0, 0, 0, 0, "R9 cascade SUB");
        issue(0, 3'b100, 0, 32'd100, 32'd1, 0, 0, 0, 0, "R9 consumer ADD");
        // R10 cascade then other class: forward dropped, flags kept
        issue(0, 3'b111, 1, 32'd4, 32'd4, 0, 0, 0, 0, "R10 cascade CMP");
        issue(3, 3'b000, 0, 32'd0, 32'd0, 0, 0, 0, 0, "R10 other class");
        issue(0, 3'b100, 0, 32'd100, 32'd1, 0, 0, 0, 0, "R10 ADD after drop");
        issue(1, 3'b000, 1, 32'h10, 32'h1, 0, 0, 0, 0, "R10 cascade IOR");
        issue(2, 3'b000, 0, 32'd0, 32'd0, 0, 0, 0, 0, "R10 shift class");
        issue(1, 3'b000, 0, 32'h20, 32'h2, 0, 0, 0, 0, "R10 IOR after shift");
        // R11 back-to-back cascades
        issue(0, 3'b001, 1, 32'd7, 32'd7, 0, 0, 0, 0, "R11 first cascade");
        issue(0, 3'b100, 1, 32'd0, 32'd2, 0, 0, 0, 0, "R11 second cascade");
        issue(0, 3'b100, 0, 32'd50, 32'd1, 0, 0, 0, 0, "R11 consumer");
        idle();
        idle();
        idle();
        check("R12 scoreboard drained", 64'(sb.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule